// File: doc/BRIEF.md
# Serial Receiver Startup and Output-Control Sequencer

This block sequences the startup of a serial receiver and gates its output drivers. It runs on the receiver's reference clock. While the active-low power control input is low, every output driver is released to high impedance. When that input returns high, the block waits a fixed number of reference cycles for the on-chip clock loop to settle. During that wait the lock indicator is driven high and the data and clock drivers stay released.

After the wait, the data and clock drivers come up and the output clock is taken from the reference. The block then waits for the frame finder to report that it has found the frame boundary. At that point the active-low lock indicator goes low and the clock-source select moves to the recovered stream clock. A data-valid qualifier rises once the chosen edge of the recovered strobe has been seen twice. An output-enable input gates only the data and clock drivers and never changes the sequencing. If the frame finder drops its flag, the block falls back to the reference clock at once.

Top module: `rx_init_seq`

## Requirements
- R1: While `pwdn_n` is sampled low at a clock edge, `lock_oe`, `dout_oe`, `rclk_oe`, `data_vld` and `clk_sel` are all 0 after that edge, and the reference-wait counter is held at zero.
- R2: Initialization restarts in full on every return of `pwdn_n` to high. A wait cut short by power-down still lasts REF_CYC edges after the next release.
- R3: At the first edge where `pwdn_n` is sampled high, the block enters the wait: `lock_oe`=1 and `lock_n`=1, while `dout_oe`=0 and `rclk_oe`=0. `frame_locked` has no effect during the wait.
- R4: Exactly REF_CYC edges (default 2048) after entering the wait, `dout_oe` and `rclk_oe` become equal to `out_en`. `clk_sel` stays 0 (reference clock) and `lock_n` stays 1.
- R5: In that active state, `frame_locked`=1 sampled at an edge drives `lock_n`=0 and `clk_sel`=1 (stream clock) after that edge.
- R6: After `lock_n` falls, `data_vld` rises two edges after the second selected transition of `strb` is presented. It is 0 before that and after only one such transition.
- R7: `edge_rise`=1 selects 0-to-1 transitions of `strb`, and `edge_rise`=0 selects 1-to-0 transitions. Transitions of the other polarity are not counted.
- R8: `out_en`=0 forces `dout_oe`=0 and `rclk_oe`=0 only. `lock_oe`, `lock_n`, `clk_sel`, `data_vld` and the wait length are unchanged by it.
- R9: With lock held, `frame_locked`=0 sampled at an edge makes `lock_n`=1, `clk_sel`=0 and `data_vld`=0 after that edge. Counting of strobe transitions then starts over.
- R10: Synchronous reset `rst` puts the block in the powered-down state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| pwdn_n | input | 1 | Power control, low = powered down |
| out_en | input | 1 | Enable for the data and clock output drivers |
| edge_rise | input | 1 | Strobe edge select, 1 = rising, 0 = falling |
| frame_locked | input | 1 | Frame boundary found by the frame finder |
| strb | input | 1 | Recovered strobe clock level |
| lock_n | output | 1 | Lock indicator, low = locked to the stream |
| lock_oe | output | 1 | Drive enable for the lock indicator |
| dout_oe | output | 1 | Drive enable for the parallel data outputs |
| rclk_oe | output | 1 | Drive enable for the output clock |
| clk_sel | output | 1 | Output clock source, 0 = reference, 1 = stream |
| data_vld | output | 1 | Parallel data qualifier |

## Verification
Power-down, lock handoff and loss of lock all take effect one edge after the input is sampled. The driver enables follow `out_en` in the same cycle. The end of the wait falls exactly REF_CYC edges after entry, and the bench probes both the edge before it and the edge at which it occurs. `data_vld` lags a strobe transition by two edges: one edge to sample the level and one to count it. Every input therefore changes on a falling clock edge, and each result is read on a later falling edge, after exactly that many rising edges.

// File: rtl/rx_init_pkg.sv
package rx_init_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAIT = 2'd1,
        ST_REF  = 2'd2,
        ST_STRM = 2'd3
    } seq_st_e;

    typedef struct packed {
        logic lock_oe;
        logic lock_n;
        logic data_oe;
        logic clk_oe;
        logic clk_sel;
    } pin_ctl_t;

    localparam int unsigned VLD_EDGES = 2;

    function automatic pin_ctl_t ctl_of(seq_st_e st, logic oe);
        pin_ctl_t c;
        c = '{lock_oe: 1'b0, lock_n: 1'b1, data_oe: 1'b0,
              clk_oe: 1'b0, clk_sel: 1'b0};
        case (st)
            ST_WAIT: c.lock_oe = 1'b1;
            ST_REF: begin
                c.lock_oe = 1'b1;
                c.data_oe = oe;
                c.clk_oe  = oe;
            end
            ST_STRM: begin
                c.lock_oe = 1'b1;
                c.lock_n  = 1'b0;
                c.data_oe = oe;
                c.clk_oe  = oe;
                c.clk_sel = 1'b1;
            end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/rx_init_fsm.sv
module rx_init_fsm
    import rx_init_pkg::*;
#(
    parameter int unsigned REF_CYC = 2048
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    pwdn_n,
    input  logic    frame_locked,
    output seq_st_e st
);
    localparam int unsigned CW = (REF_CYC > 1) ? $clog2(REF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(REF_CYC - 1);

    logic [CW-1:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (rst || !pwdn_n) begin
            st       <= ST_OFF;
            wait_cnt <= '0;
        end else begin
            case (st)
                ST_OFF: begin
                    st       <= ST_WAIT;
                    wait_cnt <= '0;
                end
                ST_WAIT: begin
                    if (wait_cnt == LAST) st <= ST_REF;
                    else                  wait_cnt <= wait_cnt + 1'b1;
                end
                ST_REF:  if (frame_locked)  st <= ST_STRM;
                ST_STRM: if (!frame_locked) st <= ST_REF;
                default: st <= ST_OFF;
            endcase
        end
    end
endmodule

// File: rtl/rx_strobe_det.sv
module rx_strobe_det #(
    parameter int unsigned SYNC_LEN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strb,
    input  logic edge_rise,
    output logic hit
);
    logic [SYNC_LEN-1:0] sh;

    generate
        if (SYNC_LEN == 2) begin : g_two
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= {sh[0], strb};
            end
        end else begin : g_long
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= {sh[SYNC_LEN-2:0], strb};
            end
        end
    endgenerate

    logic cur, prv;
    assign cur = sh[SYNC_LEN-2];
    assign prv = sh[SYNC_LEN-1];
    assign hit = edge_rise ? (cur & ~prv) : (~cur & prv);
endmodule

// File: rtl/rx_valid_gate.sv
module rx_valid_gate #(
    parameter int unsigned EDGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic hit,
    output logic vld
);
    localparam int unsigned NW = $clog2(EDGES + 1);
    localparam logic [NW-1:0] TOP = NW'(EDGES);

    logic [NW-1:0] n;

    always_ff @(posedge clk) begin
        if (rst || !en)            n <= '0;
        else if (hit && n != TOP)  n <= n + 1'b1;
    end

    assign vld = en && (n == TOP);
endmodule

// File: rtl/rx_init_seq.sv
module rx_init_seq
    import rx_init_pkg::*;
#(
    parameter int unsigned REF_CYC  = 2048,
    parameter int unsigned SYNC_LEN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pwdn_n,
    input  logic out_en,
    input  logic edge_rise,
    input  logic frame_locked,
    input  logic strb,
    output logic lock_n,
    output logic lock_oe,
    output logic dout_oe,
    output logic rclk_oe,
    output logic clk_sel,
    output logic data_vld
);
    seq_st_e  st;
    pin_ctl_t ctl;
    logic     hit;

    rx_init_fsm #(.REF_CYC(REF_CYC)) u_fsm (
        .clk(clk), .rst(rst), .pwdn_n(pwdn_n),
        .frame_locked(frame_locked), .st(st)
    );

    rx_strobe_det #(.SYNC_LEN(SYNC_LEN)) u_det (
        .clk(clk), .rst(rst), .strb(strb),
        .edge_rise(edge_rise), .hit(hit)
    );

    rx_valid_gate #(.EDGES(VLD_EDGES)) u_vld (
        .clk(clk), .rst(rst), .en(st == ST_STRM),
        .hit(hit), .vld(data_vld)
    );

    assign ctl     = ctl_of(st, out_en);
    assign lock_n  = ctl.lock_n;
    assign lock_oe = ctl.lock_oe;
    assign dout_oe = ctl.data_oe;
    assign rclk_oe = ctl.clk_oe;
    assign clk_sel = ctl.clk_sel;
endmodule

// File: rtl/rx_init_seq_chk.sv
module rx_init_seq_chk (
    input logic clk,
    input logic rst,
    input logic pwdn_n,
    input logic out_en,
    input logic frame_locked,
    input logic lock_n,
    input logic lock_oe,
    input logic dout_oe,
    input logic rclk_oe,
    input logic clk_sel,
    input logic data_vld
);
    a_r1_pdn_hiz: assert property (@(posedge clk) disable iff (rst)
        !pwdn_n |=> (!lock_oe && !dout_oe && !rclk_oe && !data_vld));

    a_r3_init_hiz: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_oe) |-> (!dout_oe && !rclk_oe && lock_n));

    a_r5_handoff: assert property (@(posedge clk) disable iff (rst)
        (pwdn_n && lock_n && dout_oe && frame_locked) |=> (!lock_n && clk_sel));

    a_r6_vld_locked: assert property (@(posedge clk) disable iff (rst)
        data_vld |-> (!lock_n && clk_sel && lock_oe));

    a_r6_vld_not_early: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_n) |-> !data_vld);

    a_r8_oe_gate: assert property (@(posedge clk) disable iff (rst)
        !out_en |-> (!dout_oe && !rclk_oe));

    a_r9_loss: assert property (@(posedge clk) disable iff (rst)
        (pwdn_n && lock_oe && !lock_n && !frame_locked) |=>
        (lock_n && !clk_sel && !data_vld));
endmodule

bind rx_init_seq rx_init_seq_chk u_chk (
    .clk(clk), .rst(rst), .pwdn_n(pwdn_n), .out_en(out_en),
    .frame_locked(frame_locked), .lock_n(lock_n), .lock_oe(lock_oe),
    .dout_oe(dout_oe), .rclk_oe(rclk_oe), .clk_sel(clk_sel),
    .data_vld(data_vld)
);

// File: tb/rx_init_seq_tb_top.sv
module rx_init_seq_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  REF_CYC    = 2048;

    logic clk = 1'b0;
    logic rst, pwdn_n, out_en, edge_rise, frame_locked, strb;
    logic lock_n, lock_oe, dout_oe, rclk_oe, clk_sel, data_vld;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rx_init_seq #(.REF_CYC(REF_CYC)) dut_i (
        .clk(clk), .rst(rst), .pwdn_n(pwdn_n), .out_en(out_en),
        .edge_rise(edge_rise), .frame_locked(frame_locked), .strb(strb),
        .lock_n(lock_n), .lock_oe(lock_oe), .dout_oe(dout_oe),
        .rclk_oe(rclk_oe), .clk_sel(clk_sel), .data_vld(data_vld)
    );

    // entry = {frame_locked, edge_rise, strb, exp_lock_n, exp_vld}
    localparam logic [4:0] VEC [10] = '{
        5'b1_1_0_0_0,  // R5 handoff, no strobe transition yet
        5'b1_1_1_0_0,  // R6 first rising transition
        5'b1_1_0_0_0,  // R7 falling ignored with rising selected
        5'b1_1_1_0_1,  // R6 second rising -> valid
        5'b1_1_0_0_1,  // R6 valid holds
        5'b0_1_0_1_0,  // R9 loss of lock
        5'b1_0_1_0_0,  // R7 rising ignored with falling selected
        5'b1_0_0_0_0,  // R7 first falling
        5'b1_0_1_0_0,  // R7 rising still ignored
        5'b1_0_0_0_1   // R7 second falling -> valid
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    initial begin
        rst = 1'b1; pwdn_n = 1'b0; out_en = 1'b1; edge_rise = 1'b1;
        frame_locked = 1'b0; strb = 1'b0;
        tick(3);
        rst = 1'b0;
        // R10 reset state
        chk("R10 lock_oe", lock_oe, 1'b0);
        chk("R10 dout_oe", dout_oe, 1'b0);
        chk("R10 data_vld", data_vld, 1'b0);
        tick(2);
        // R1 held in power-down
        chk("R1 rclk_oe", rclk_oe, 1'b0);
        chk("R1 lock_oe", lock_oe, 1'b0);

        // R2 partial wait then power-down, then full restart
        pwdn_n = 1'b1;
        tick(1);
        chk("R3 lock_oe on entry", lock_oe, 1'b1);
        tick(1000);
        pwdn_n = 1'b0;
        tick(1);
        chk("R1 lock_oe mid-wait", lock_oe, 1'b0);
        pwdn_n = 1'b1;
        tick(1);
        chk("R3 lock_n in wait", lock_n, 1'b1);
        chk("R3 dout_oe in wait", dout_oe, 1'b0);
        for (int i = 1; i < REF_CYC; i++) begin
            out_en = ~out_en;       // R8 toggling must not shift timing
            if (i == 100) frame_locked = 1'b1;
            if (i == 200) begin
                chk("R3 frame_locked ignored lock_n", lock_n, 1'b1);
                chk("R3 frame_locked ignored clk_sel", clk_sel, 1'b0);
                frame_locked = 1'b0;
            end
            tick(1);
        end
        out_en = 1'b1;
        #1;
        chk("R2 dout_oe one edge before end", dout_oe, 1'b0);
        chk("R3 rclk_oe one edge before end", rclk_oe, 1'b0);
        tick(1);
        chk("R4 dout_oe after wait", dout_oe, 1'b1);
        chk("R4 rclk_oe after wait", rclk_oe, 1'b1);
        chk("R4 clk_sel reference", clk_sel, 1'b0);
        chk("R4 lock_n high", lock_n, 1'b1);
        out_en = 1'b0;
        #1;
        chk("R8 dout_oe gated", dout_oe, 1'b0);
        chk("R8 lock_oe kept", lock_oe, 1'b1);
        out_en = 1'b1;

        // Table of stimulus and expected results
        foreach (VEC[k]) begin
            frame_locked = VEC[k][4];
            edge_rise    = VEC[k][3];
            strb         = VEC[k][2];
            tick(1);
            if (k == 0 || k == 5)
                chk(k == 0 ? "R5 lock_n after one edge" : "R9 vld after one edge",
                    k == 0 ? lock_n : data_vld, k == 0 ? 1'b0 : 1'b0);
            tick(1);
            chk($sformatf("R6/R7 vec %0d lock_n", k), lock_n, VEC[k][1]);
            chk($sformatf("R5/R9 vec %0d clk_sel", k), clk_sel, ~VEC[k][1]);
            chk($sformatf("R6/R7 vec %0d data_vld", k), data_vld, VEC[k][0]);
        end

        // R8 output enable while valid
        out_en = 1'b0;
        tick(3);
        chk("R8 dout_oe off", dout_oe, 1'b0);
        chk("R8 rclk_oe off", rclk_oe, 1'b0);
        chk("R8 lock_n kept", lock_n, 1'b0);
        chk("R8 data_vld kept", data_vld, 1'b1);
        chk("R8 clk_sel kept", clk_sel, 1'b1);
        out_en = 1'b1;

        // R1 power-down from stream lock
        pwdn_n = 1'b0;
        tick(1);
        chk("R1 lock_oe off", lock_oe, 1'b0);
        chk("R1 data_vld off", data_vld, 1'b0);
        chk("R1 clk_sel ref", clk_sel, 1'b0);
        chk("R1 dout_oe off", dout_oe, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule